// File: doc/BRIEF.md
# Refresh Timer with Command Admission Window

This block measures the time since the most recent refresh of an SDRAM device and turns it into two signals for the controller's main state machine. Once the power-up sequence reports that it is complete, a cycle counter starts. When the counter reaches a configurable refresh interval, the block raises a refresh request. The request stays up until the state machine reports that a refresh has finished.

Every finished refresh restarts the timing from zero. This includes the timer's own refresh and a refresh forced early, such as the one issued straight after a long read or write burst. For a short span after each restart, the block also raises an admission flag. The state machine accepts new read or write bursts only while that flag is high. A burst started in that span can then run to completion before the next periodic refresh becomes due.

Top module: `refresh_window_timer`

## Requirements
- R1: While the active-low asynchronous reset is asserted, `refreshReq` and `cmdWindow` are 0, and any earlier timing progress is discarded.
- R2: Until `initDone` has been sampled high at a rising clock edge, `refreshReq` and `cmdWindow` stay 0, even when `refreshDone` pulses.
- R3: The first edge that samples `initDone` high makes the elapsed count 0. `cmdWindow` is then high for exactly `WINDOW_CYC` cycles and falls after them.
- R4: `refreshReq` rises `INTERVAL_CYC` cycles after the timing starts or restarts, and not sooner.
- R5: Once raised, `refreshReq` stays high without limit until a `refreshDone` pulse is sampled. The count saturates and does not wrap, so `cmdWindow` does not reopen.
- R6: An edge that samples `refreshDone` high while timing is active clears `refreshReq`, raises `cmdWindow` and restarts the count from 0.
- R7: A `refreshDone` pulse that arrives before the interval expires also restarts the timing. This reopens the window for `WINDOW_CYC` cycles and postpones the request by a full `INTERVAL_CYC` from that point.
- R8: `refreshReq` and `cmdWindow` are never high in the same cycle. The parameters require `WINDOW_CYC < INTERVAL_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initDone | input | 1 | Power-up sequence complete; level |
| refreshDone | input | 1 | One-cycle pulse: a refresh has finished |
| refreshReq | output | 1 | Refresh is due; held until refreshDone |
| cmdWindow | output | 1 | Read/write bursts may be admitted |

## Verification
A counter that advanced one step too early or too late would move the fall of `cmdWindow` or the rise of `refreshReq` by one cycle. The bench samples both edges on the exact cycle they are due, so this shows immediately. A missed clear on `refreshDone` would keep `refreshReq` high, or keep the window shut, on the cycle right after the pulse. A counter that wrapped instead of saturating would reopen `cmdWindow` while a request is still pending, within one interval of waiting.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  // Strobes from the control to the elapsed-time datapath
  typedef struct packed {
    logic clear;    // restart the count from zero
    logic advance;  // count one more cycle
  } cntStrobes_t;
endpackage

// File: rtl/rwt_counter.sv
module rwt_counter
  import rwt_pkg::*;
#(
  parameter int INTERVAL_CYC = 770,
  parameter int WINDOW_CYC   = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  cntStrobes_t strobes,
  output logic        atLimit,
  output logic        inWindow
);
  localparam int CNT_W = $clog2(INTERVAL_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT_V  = CNT_W'(INTERVAL_CYC);
  localparam logic [CNT_W-1:0] WINDOW_V = CNT_W'(WINDOW_CYC);

  logic [CNT_W-1:0] elapsedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                elapsedQ <= '0;
    else if (strobes.clear)   elapsedQ <= '0;
    else if (strobes.advance) elapsedQ <= elapsedQ + 1'b1;
  end

  assign atLimit  = (elapsedQ == LIMIT_V);
  assign inWindow = (elapsedQ < WINDOW_V);
endmodule

// File: rtl/rwt_control.sv
module rwt_control
  import rwt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initDone,
  input  logic        refreshDone,
  input  logic        atLimit,
  input  logic        inWindow,
  output cntStrobes_t strobes,
  output logic        refreshReq,
  output logic        cmdWindow
);
  logic armedQ;

  // Timing becomes active on the first edge that sees init complete
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armedQ <= 1'b0;
    else if (initDone) armedQ <= 1'b1;
  end

  always_comb begin
    strobes.clear   = refreshDone;
    // Saturate at the limit: the count never wraps while a request is pending
    strobes.advance = armedQ && !atLimit && !refreshDone;
  end

  assign refreshReq = armedQ && atLimit;
  assign cmdWindow  = armedQ && inWindow;
endmodule

// File: rtl/refresh_window_timer.sv
module refresh_window_timer #(
  parameter int INTERVAL_CYC = 770,
  parameter int WINDOW_CYC   = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic initDone,
  input  logic refreshDone,
  output logic refreshReq,
  output logic cmdWindow
);
  import rwt_pkg::*;

  cntStrobes_t strobes;
  logic        atLimit;
  logic        inWindow;

  rwt_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .initDone   (initDone),
    .refreshDone(refreshDone),
    .atLimit    (atLimit),
    .inWindow   (inWindow),
    .strobes    (strobes),
    .refreshReq (refreshReq),
    .cmdWindow  (cmdWindow)
  );

  rwt_counter #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .WINDOW_CYC  (WINDOW_CYC)
  ) u_counter (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .atLimit (atLimit),
    .inWindow(inWindow)
  );
endmodule

// File: rtl/refresh_window_timer_checker.sv
module refresh_window_timer_checker (
  input logic clk,
  input logic rstN,
  input logic initDone,
  input logic refreshDone,
  input logic refreshReq,
  input logic cmdWindow
);
  logic seenInitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenInitQ <= 1'b0;
    else if (initDone) seenInitQ <= 1'b1;
  end

  assert_quiet_before_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    !seenInitQ |-> (!refreshReq && !cmdWindow));

  assert_window_falls_alone_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdWindow) |-> !$past(refreshDone));

  assert_req_not_after_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshReq) |-> !$past(refreshDone));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refreshDone) |=> refreshReq);

  assert_done_restarts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshDone && seenInitQ) |=> (!refreshReq && cmdWindow));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(refreshReq && cmdWindow));
endmodule

bind refresh_window_timer refresh_window_timer_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .initDone   (initDone),
  .refreshDone(refreshDone),
  .refreshReq (refreshReq),
  .cmdWindow  (cmdWindow)
);

// File: tb/refresh_window_timer_bench.sv
module refresh_window_timer_bench;
  localparam int INTERVAL = 770;
  localparam int WINDOW   = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initDone = 1'b0;
  logic refreshDone = 1'b0;
  logic refreshReq, cmdWindow;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  refresh_window_timer #(.INTERVAL_CYC(INTERVAL), .WINDOW_CYC(WINDOW)) u_refresh_window_timer (
    .clk(clk), .rstN(rstN), .initDone(initDone), .refreshDone(refreshDone),
    .refreshReq(refreshReq), .cmdWindow(cmdWindow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect2(input string tag, input logic expReq, input logic expWin);
    checks++;
    if (refreshReq !== expReq || cmdWindow !== expWin) begin
      errors++;
      $display("FAIL %s: req=%b win=%b expected req=%b win=%b at %0t",
               tag, refreshReq, cmdWindow, expReq, expWin, $time);
    end
  endtask

  // Pulse refreshDone for one edge; on return the count is 0
  task automatic pulseDone();
    refreshDone = 1'b1;
    tick(1);
    refreshDone = 1'b0;
  endtask

  // R8 monitored every cycle
  always @(negedge clk) begin
    if (rstN && refreshReq && cmdWindow) begin
      errors++;
      $display("FAIL R8: req=1 win=1 expected not both high at %0t", $time);
    end
  end

  task automatic testReset();
    expect2("R1 in reset", 1'b0, 1'b0);
    tick(3);
    rstN = 1'b1;
    tick(1);
    expect2("R1 after release", 1'b0, 1'b0);
  endtask

  task automatic testPreInit();
    tick(5);
    pulseDone();
    expect2("R2 done ignored", 1'b0, 1'b0);
    tick(INTERVAL + 20);
    expect2("R2 long wait", 1'b0, 1'b0);
  endtask

  task automatic testFirstInterval();
    initDone = 1'b1;
    tick(1);  // count 0
    expect2("R3 window opens", 1'b0, 1'b1);
    tick(WINDOW - 1);
    expect2("R3 window last cycle", 1'b0, 1'b1);
    tick(1);
    expect2("R3 window closed", 1'b0, 1'b0);
    tick(INTERVAL - WINDOW - 1);
    expect2("R4 not yet due", 1'b0, 1'b0);
    tick(1);
    expect2("R4 request due", 1'b1, 1'b0);
  endtask

  task automatic testHold();
    tick(INTERVAL + 50);
    expect2("R5 request held, no wrap", 1'b1, 1'b0);
  endtask

  task automatic testDoneClears();
    pulseDone();
    expect2("R6 cleared and window", 1'b0, 1'b1);
    tick(INTERVAL - 1);
    expect2("R6 restart not yet due", 1'b0, 1'b0);
    tick(1);
    expect2("R6 restart due", 1'b1, 1'b0);
  endtask

  task automatic testEarlyRefresh();
    pulseDone();
    tick(300);
    expect2("R7 mid-interval", 1'b0, 1'b0);
    pulseDone();
    expect2("R7 window reopens", 1'b0, 1'b1);
    tick(WINDOW - 1);
    expect2("R7 window last cycle", 1'b0, 1'b1);
    tick(1);
    expect2("R7 window closed", 1'b0, 1'b0);
    tick(INTERVAL - WINDOW - 1);
    expect2("R7 request postponed", 1'b0, 1'b0);
    tick(1);
    expect2("R7 request due", 1'b1, 1'b0);
  endtask

  task automatic testAsyncReset();
    #3 rstN = 1'b0;
    #1 expect2("R1 async clear", 1'b0, 1'b0);
    tick(2);
    rstN = 1'b1;
    tick(1);  // initDone still high: armed, count 0
    expect2("R1 restart after reset", 1'b0, 1'b1);
  endtask

  initial begin
    tick(1);
    testReset();
    testPreInit();
    testFirstInterval();
    testHold();
    testDoneClears();
    testEarlyRefresh();
    testAsyncReset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule